// File: doc/BRIEF.md
# Selectable-Source Interrupt Pin Generator

This block drives one active-low interrupt pin. It has two kinds of source. The first is a bank of sticky status bits, one for each event input. The second is a start-of-frame indication that a packet decoder outside this block raises. Each status bit sets on its event pulse and stays set until software writes a one to its position in the clear port. Only bits that are set and also enabled in the mask can pull the pin low. A start-of-frame pulse sets a separate pending flag. A read strobe on the status register clears that flag.

Two configuration bits pick which sources can drive the pin, and they live in two different configuration registers. The frame-only bit is bit 7 of the clock-divider register. The pin-mode bit is bit 5 of the interrupt-configuration register. The block decodes the two bits into three modes:

| Mode | Frame-only bit | Pin-mode bit | Pin sources |
|------|----------------|--------------|-------------|
| 0 | 0 | 0 | enabled status bits only |
| 1 | 0 | 1 | enabled status bits or the frame flag |
| 2 | 1 | don't care | frame flag only |

The pin comes from a flop, so it cannot glitch.

Top module: `irq_pin_gen`

## Requirements
- R1: After reset, every status bit reads 0, the start-of-frame flag is clear, both configuration bits are 0 (mode 0), and `irq_n_o` is 1.
- R2: A 1 on `evt_i[k]` at a clock edge sets status bit k. The bit stays set on later edges and is visible on `stat_o[k]`.
- R3: On an edge where `clr_we_i` is 1, each status bit whose `clr_bits_i` bit is 1 clears and each bit whose `clr_bits_i` bit is 0 keeps its value. If an event for a bit arrives on the same edge as its clear, the event wins and the bit ends up set.
- R4: A 1 on `sof_i` sets the start-of-frame flag. A 1 on `stat_rd_i` clears the flag. If both arrive on the same edge, the flag ends up set.
- R5: In mode 0, the pin is low exactly when some status bit is set and its `mask_i` bit is 1. The start-of-frame flag has no effect on the pin.
- R6: In mode 1, the pin is low when an enabled status bit is set or when the start-of-frame flag is set.
- R7: In mode 2, the pin is low exactly when the start-of-frame flag is set. Status bits have no effect on the pin, and the pin-mode bit's value does not matter.
- R8: A write with `cdiv_we_i` loads the frame-only bit from `wdata_i[7]`. A write with `icfg_we_i` loads the pin-mode bit from `wdata_i[5]`. All other bits of `wdata_i` are ignored.
- R9: Clearing a bit's mask bit stops that bit from affecting the pin, but the bit is still held and still shown on `stat_o`.
- R10: The pin is registered. It reflects the pending state and the mode that were present at the previous clock edge. It therefore goes high on the edge after the last qualifying condition clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event pulse for each status bit |
| sof_i | input | 1 | Start-of-frame event pulse |
| mask_i | input | NUM_SRC | Enable for each status bit |
| clr_we_i | input | 1 | Strobe for the write-one-to-clear of the status bits |
| clr_bits_i | input | NUM_SRC | Bits to clear; a 1 clears that position |
| stat_rd_i | input | 1 | Status register read strobe; clears the start-of-frame flag |
| cdiv_we_i | input | 1 | Write strobe for the clock-divider register |
| icfg_we_i | input | 1 | Write strobe for the interrupt-configuration register |
| wdata_i | input | REG_W | Register write data |
| stat_o | output | NUM_SRC | Current status bits |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
Wrong internal state shows up in two places:

- A status bit that fails to set, fails to hold, or clears when it should not shows up on `stat_o` on the very next cycle.
- A wrong start-of-frame flag or a wrong mode bit shows up only on the pin. It appears one cycle later, and only while the current mode lets that source through.

For this reason the stimulus cycles through every mode, including mode 2 reached with both values of the pin-mode bit. Within each mode it toggles the mask, so that hidden state gets a chance to reach the pin.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

   typedef enum logic [1:0] {
      IRQ_MODE_STAT = 2'd0,
      IRQ_MODE_BOTH = 2'd1,
      IRQ_MODE_SOF  = 2'd2
   } irq_mode_e;

   // frame-only bit has priority over the pin-mode bit
   function automatic irq_mode_e irq_decode_mode(input logic frame_only,
                                                 input logic pin_mode);
      irq_mode_e m;
      if (frame_only)    m = IRQ_MODE_SOF;
      else if (pin_mode) m = IRQ_MODE_BOTH;
      else               m = IRQ_MODE_STAT;
      return m;
   endfunction

   function automatic logic irq_select_req(input irq_mode_e mode,
                                           input logic      stat_hit,
                                           input logic      frame_hit);
      logic r;
      case (mode)
         IRQ_MODE_STAT: r = stat_hit;
         IRQ_MODE_BOTH: r = stat_hit | frame_hit;
         IRQ_MODE_SOF:  r = frame_hit;
         default:       r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int unsigned NUM_SRC  = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC-1:0] clr_bits_i,
   output logic [NUM_SRC-1:0] pend_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_width
         $error("irq_sticky_bank: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] kill;
   assign kill = clr_we_i ? clr_bits_i : '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic pend_q;
      logic pend_d;

      if (SET_WINS) begin : g_set_first
         assign pend_d = (pend_q & ~kill[g]) | evt_i[g];
      end else begin : g_clr_first
         assign pend_d = (pend_q | evt_i[g]) & ~kill[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= pend_d;
      end

      assign pend_o[g] = pend_q;

      // R2
      evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[g] && !kill[g]) |=> pend_o[g]);

      // R2
      bit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt_i[g] && !kill[g]) |=> $stable(pend_o[g]));

      // R3
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (kill[g] && !evt_i[g]) |=> !pend_o[g]);

      if (SET_WINS) begin : g_set_first_chk
         // R3
         evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (kill[g] && evt_i[g]) |=> pend_o[g]);
      end
   end

endmodule

// File: rtl/irq_sof_flag.sv
module irq_sof_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_i,
   input  logic rd_i,
   output logic flag_o
);

   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         assign flag_d = (flag_q & ~rd_i) | sof_i;
      end else begin : g_clr_first
         assign flag_d = (flag_q | sof_i) & ~rd_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

   // R4
   sof_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !rd_i) |=> flag_o);

   // R4
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !sof_i) |=> !flag_o);

   // R4
   flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && !sof_i) |=> $stable(flag_o));

endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
   import irq_pin_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cdiv_we_i,
   input  logic      icfg_we_i,
   input  logic      frame_only_wbit_i,
   input  logic      pin_mode_wbit_i,
   output irq_mode_e mode_o
);

   logic frame_only_q;
   logic pin_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_only_q <= 1'b0;
         pin_mode_q   <= 1'b0;
      end else begin
         if (cdiv_we_i) frame_only_q <= frame_only_wbit_i;
         if (icfg_we_i) pin_mode_q   <= pin_mode_wbit_i;
      end
   end

   assign mode_o = irq_decode_mode(frame_only_q, pin_mode_q);

   // R8
   cdiv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdiv_we_i && frame_only_wbit_i) |=> (mode_o == IRQ_MODE_SOF));

   // R8
   mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cdiv_we_i && !icfg_we_i) |=> $stable(mode_o));

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_pin_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               frame_pend_i,
   input  irq_mode_e          mode_i,
   output logic               irq_n_o
);

   logic stat_hit;
   logic req;
   logic irq_n_q;

   assign stat_hit = |(pend_i & mask_i);
   assign req      = irq_select_req(mode_i, stat_hit, frame_pend_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~req;
   end

   assign irq_n_o = irq_n_q;

   // R5
   stat_mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == IRQ_MODE_STAT && (|(pend_i & mask_i))) |=> !irq_n_o);

   // R5
   stat_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == IRQ_MODE_STAT && !(|(pend_i & mask_i))) |=> irq_n_o);

   // R6
   both_mode_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == IRQ_MODE_BOTH && frame_pend_i) |=> !irq_n_o);

   // R7
   sof_mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == IRQ_MODE_SOF && frame_pend_i) |=> !irq_n_o);

   // R7
   sof_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == IRQ_MODE_SOF && !frame_pend_i) |=> irq_n_o);

endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
   import irq_pin_pkg::*;
#(
   parameter int unsigned NUM_SRC        = 8,
   parameter int unsigned REG_W          = 8,
   parameter int unsigned FRAME_ONLY_POS = 7,
   parameter int unsigned PIN_MODE_POS   = 5,
   parameter bit          SET_WINS       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               sof_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC-1:0] clr_bits_i,
   input  logic               stat_rd_i,
   input  logic               cdiv_we_i,
   input  logic               icfg_we_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [NUM_SRC-1:0] stat_o,
   output logic               irq_n_o
);

   generate
      if (FRAME_ONLY_POS >= REG_W) begin : g_bad_fo
         $error("irq_pin_gen: FRAME_ONLY_POS outside register");
      end
      if (PIN_MODE_POS >= REG_W) begin : g_bad_pm
         $error("irq_pin_gen: PIN_MODE_POS outside register");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;
   logic               frame_pend;
   irq_mode_e          mode;
   logic               unused_wdata;

   assign unused_wdata = ^wdata_i;

   irq_sticky_bank #(
      .NUM_SRC  (NUM_SRC),
      .SET_WINS (SET_WINS)
   ) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_we_i   (clr_we_i),
      .clr_bits_i (clr_bits_i),
      .pend_o     (pend)
   );

   irq_sof_flag #(
      .SET_WINS (SET_WINS)
   ) i_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sof_i  (sof_i),
      .rd_i   (stat_rd_i),
      .flag_o (frame_pend)
   );

   irq_mode_regs i_mode (
      .clk               (clk),
      .rst_n             (rst_n),
      .cdiv_we_i         (cdiv_we_i),
      .icfg_we_i         (icfg_we_i),
      .frame_only_wbit_i (wdata_i[FRAME_ONLY_POS]),
      .pin_mode_wbit_i   (wdata_i[PIN_MODE_POS]),
      .mode_o            (mode)
   );

   irq_pin_drive #(
      .NUM_SRC (NUM_SRC)
   ) i_pin (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_i       (pend),
      .mask_i       (mask_i),
      .frame_pend_i (frame_pend),
      .mode_i       (mode),
      .irq_n_o      (irq_n_o)
   );

   assign stat_o = pend;

   // R9
   mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == IRQ_MODE_STAT && mask_i == '0) |=> irq_n_o);

endmodule

// File: tb/test_irq_pin_gen.sv
module test_irq_pin_gen;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic         sof = 1'b0;
   logic [N-1:0] mask = '1;
   logic         clr_we = 1'b0;
   logic [N-1:0] clr_bits = '0;
   logic         rd = 1'b0;
   logic         cdiv_we = 1'b0;
   logic         icfg_we = 1'b0;
   logic [7:0]   wdata = '0;
   logic [N-1:0] stat;
   logic         irq_n;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   irq_pin_gen i_irq_pin_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .sof_i      (sof),
      .mask_i     (mask),
      .clr_we_i   (clr_we),
      .clr_bits_i (clr_bits),
      .stat_rd_i  (rd),
      .cdiv_we_i  (cdiv_we),
      .icfg_we_i  (icfg_we),
      .wdata_i    (wdata),
      .stat_o     (stat),
      .irq_n_o    (irq_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   logic [N-1:0] m_pend;
   bit           m_sof, m_fo, m_pm, m_pin;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0; m_sof = 0; m_fo = 0; m_pm = 0; m_pin = 1;
      end else begin
         bit hit, req;
         hit = (m_pend & mask) != '0;
         if (m_fo)      req = m_sof;
         else if (m_pm) req = hit || m_sof;
         else           req = hit;
         m_pin = !req;
         for (int k = 0; k < N; k++) begin
            if (evt[k])                        m_pend[k] = 1'b1;
            else if (clr_we && clr_bits[k])    m_pend[k] = 1'b0;
         end
         if (sof)     m_sof = 1;
         else if (rd) m_sof = 0;
         if (cdiv_we) m_fo = wdata[7];
         if (icfg_we) m_pm = wdata[5];
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare with the reference on every cycle, away from the edge
   task automatic compare_model();
      string ptag;
      if (m_fo)      ptag = "R7/R10 pin";
      else if (m_pm) ptag = "R6/R10 pin";
      else           ptag = "R5/R10 pin";
      check("R2/R3 status", 32'(stat), 32'(m_pend));
      check(ptag, 32'(irq_n), 32'(m_pin));
   endtask

   task automatic idle_inputs();
      evt = '0; sof = 0; clr_we = 0; clr_bits = '0; rd = 0;
      cdiv_we = 0; icfg_we = 0; wdata = '0;
   endtask

   task automatic step();
      @(negedge clk);
      compare_model();
      idle_inputs();
   endtask

   task automatic write_cfg(input bit fo, input bit pm);
      step();
      cdiv_we = 1; icfg_we = 1;
      wdata = {fo, 1'b1, pm, 5'b11111};
      wdata[6] = ~fo; wdata[4] = ~pm;
   endtask

   task automatic random_run(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         step();
         for (int k = 0; k < N; k++) evt[k] = ($urandom_range(0, 11) == 0);
         sof = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 5) == 0) begin
            clr_we = 1; clr_bits = N'($urandom);
         end
         rd = ($urandom_range(0, 6) == 0);
         if ($urandom_range(0, 29) == 0) mask = N'($urandom);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pin", 32'(irq_n), 32'd1);
      check("R1 status", 32'(stat), 32'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1 pin after release", 32'(irq_n), 32'd1);

      // R5 / R4: frame flag alone does not drive the pin in mode 0
      sof = 1;
      step();
      step();
      check("R5 frame ignored", 32'(irq_n), 32'd1);

      // R10: pin follows one clock after the bit sets
      evt = 8'h08;
      @(negedge clk);
      check("R10 pin lags", 32'(irq_n), 32'd1);
      check("R2 bit set", 32'(stat), 32'h08);
      idle_inputs();
      @(negedge clk);
      check("R10 pin asserted", 32'(irq_n), 32'd0);

      // R3: event and clear on the same edge -> bit stays
      clr_we = 1; clr_bits = 8'h08; evt = 8'h08;
      @(negedge clk);
      check("R3 event wins", 32'(stat), 32'h08);
      idle_inputs();
      clr_we = 1; clr_bits = 8'h08;
      @(negedge clk);
      check("R3 cleared", 32'(stat), 32'h00);
      idle_inputs();
      @(negedge clk);
      check("R10 pin released", 32'(irq_n), 32'd1);

      // R9: masked bit held but silent
      mask = 8'hFE; evt = 8'h01;
      step();
      step();
      check("R9 held", 32'(stat), 32'h01);
      check("R9 silent", 32'(irq_n), 32'd1);

      // R8: bit 7 clear, other bits set -> no change to mode 0
      cdiv_we = 1; wdata = 8'h7F;
      step();
      step();
      check("R8 no mode change", 32'(irq_n), 32'd1);

      // R6: mode 1, pending frame flag (set earlier, not read) drives pin
      icfg_we = 1; wdata = 8'h20;
      step();
      step();
      check("R6 frame drives", 32'(irq_n), 32'd0);

      // R4: read clears the flag
      rd = 1;
      step();
      step();
      check("R4 read clears", 32'(irq_n), 32'd1);

      // R7: mode 2 with pin-mode 0, status bits ignored
      mask = '1;
      cdiv_we = 1; icfg_we = 1; wdata = 8'h80;
      step();
      step();
      check("R7 status ignored", 32'(irq_n), 32'd1);
      sof = 1; rd = 1;
      step();
      step();
      check("R4/R7 set beats read", 32'(irq_n), 32'd0);
      rd = 1;
      step();

      write_cfg(0, 0); random_run(600);
      write_cfg(0, 1); random_run(600);
      write_cfg(1, 0); random_run(600);
      write_cfg(1, 1); random_run(600);
      write_cfg(0, 0); random_run(300);
      step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule